// File: doc/BRIEF.md
# DDR3 Power-Up Command Sequencer

This block brings a DDR3 memory out of reset by driving a one-word command port of a memory controller through a fixed bring-up series. A start pulse latches three timing values given in clock cycles: write recovery, CAS latency and CAS write latency. The block then raises a power-up request and waits, within a bounded number of cycles, for the controller's power-up-complete flag.

When that flag arrives, the block writes seven command words to both ranks in order. It sends a deselect, waits a programmable settling gap, sends a precharge of all banks, and then loads the four mode registers in the order 2, 3, 1, 0. A long ZQ calibration closes the series. The mode-register contents are derived from the latched timing values.

Each command word carries a start flag. The controller holds this flag readable, as a pending input, until it has consumed the word. No further word is written while that input is high. The result is given as a held done or error level, and a busy level covers the whole run.

Top module: `ddr3_bringup_seq`

## Requirements
- R1: While reset is asserted, and after its release, busy_o, done_o, err_o, pwr_req_o and cmd_wr_o are all low.
- R2: A start_i pulse while idle raises busy_o and pwr_req_o on the following cycle and clears done_o and err_o. A start_i pulse while busy_o is high has no effect: the latched timing values and the command series are unchanged.
- R3: Every word written with cmd_wr_o has bit 31 (start flag) set and bits 21 and 20 (rank 1 and rank 0 selects) both set. Its opcode is in bits 3:0, with deselect=0, precharge-all=1, mode-register set=3 and long ZQ calibration=5. For non-MRS words, all other bits are zero.
- R4: After power-up completes, exactly seven words are written in this order: deselect, precharge-all, MRS to MR2, MRS to MR3, MRS to MR1, MRS to MR0, long ZQ calibration.
- R5: In an MRS word, the mode-register number sits in bits 18:17 and the 13-bit register data in bits 16:4.
- R6: cmd_pending_i must be high from the cycle after a write until the word is consumed. No word is written while cmd_pending_i is high; the next word follows only once it reads low.
- R7: Between the write of the deselect and the write of the precharge-all, at least GAP_CYC+1 cycles pass. The other gaps between successive words carry no such delay.
- R8: MR0 bits 11:9 hold the write-recovery code. A write recovery n above 8 is first rounded up to even; the code is then n-4 if n is at most 8, and (n/2) mod 8 otherwise.
- R9: MR0 bits 6:4 hold (CL-4) mod 8, bit 2 holds bit 3 of (CL-4), and bit 8 (DLL reset) is set. Bits 1:0 are zero, which selects a burst length of 8.
- R10: MR1 equals 0x040 (termination bit 6 only). MR2 holds (CWL-5) mod 8 in bits 5:3 and is zero elsewhere. MR3 is zero.
- R11: If pwr_done_i is not seen within PWR_TIMEOUT_CYC cycles of power-up request, err_o rises, busy_o falls, and no command word is written.
- R12: done_o rises in the same cycle that busy_o falls after the last word is consumed. done_o and err_o are never high together, and either one holds until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a bring-up run (sampled while idle) |
| twr_i | input | TW | Write recovery in clock cycles |
| tcl_i | input | TW | CAS latency in clock cycles |
| tcwl_i | input | TW | CAS write latency in clock cycles |
| pwr_req_o | output | 1 | Power-up request, high while waiting for completion |
| pwr_done_i | input | 1 | Power-up complete flag from controller |
| cmd_wr_o | output | 1 | One-cycle write strobe for cmd_word_o |
| cmd_word_o | output | 32 | Packed command word |
| cmd_pending_i | input | 1 | Readback of the start flag; high while a word is unconsumed |
| busy_o | output | 1 | High from accepted start until done or error |
| done_o | output | 1 | Run finished normally (held) |
| err_o | output | 1 | Power-up timed out (held) |

## Verification
The bench runs the full series with several timing sets. The write-recovery values are chosen to cover both encoding branches: the 8 boundary, an odd value above 8 that must round up, the even values 12 and 16, and a wrap to code 0. CAS latency values cover CL-4 both below and above 8, so the relocated bit 2 is seen both set and clear. Controller acknowledge latency and power-up latency are varied to separate a correct handshake wait from one that writes early or reads the flag at the wrong time. A run with no power-up completion checks the timeout path, and a second start in mid-run checks that the latched values are kept.

// File: rtl/ddr3i_pkg.sv
package ddr3i_pkg;

  localparam int unsigned WORD_W    = 32;
  localparam int unsigned START_POS = 31;
  localparam int unsigned RK1_POS   = 21;
  localparam int unsigned RK0_POS   = 20;
  localparam int unsigned MRN_LSB   = 17;
  localparam int unsigned MRD_LSB   = 4;
  localparam int unsigned MRD_W     = 13;
  localparam int unsigned NSTEP     = 7;

  typedef enum logic [3:0] {
    OP_DESEL = 4'd0,
    OP_PREA  = 4'd1,
    OP_REF   = 4'd2,
    OP_MRS   = 4'd3,
    OP_ZQCS  = 4'd4,
    OP_ZQCL  = 4'd5,
    OP_RSTL  = 4'd6,
    OP_MRR   = 4'd8,
    OP_DPDE  = 4'd9
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PWRUP,
    ST_ISSUE,
    ST_ACKW,
    ST_GAP
  } state_e;

  typedef struct packed {
    op_e        op;
    logic [1:0] mr_sel;
  } step_t;

  // Fixed bring-up order; index 0 is followed by the settling gap.
  function automatic step_t step_of(input logic [2:0] idx);
    step_t s;
    case (idx)
      3'd0:    s = '{op: OP_DESEL, mr_sel: 2'd0};
      3'd1:    s = '{op: OP_PREA,  mr_sel: 2'd0};
      3'd2:    s = '{op: OP_MRS,   mr_sel: 2'd2};
      3'd3:    s = '{op: OP_MRS,   mr_sel: 2'd3};
      3'd4:    s = '{op: OP_MRS,   mr_sel: 2'd1};
      3'd5:    s = '{op: OP_MRS,   mr_sel: 2'd0};
      default: s = '{op: OP_ZQCL,  mr_sel: 2'd0};
    endcase
    return s;
  endfunction

endpackage

// File: rtl/ddr3i_mr_build.sv
module ddr3i_mr_build
  import ddr3i_pkg::*;
#(
  parameter int unsigned TW = 5
) (
  input  logic [TW-1:0]             twr_i,
  input  logic [TW-1:0]             tcl_i,
  input  logic [TW-1:0]             tcwl_i,
  output logic [3:0][MRD_W-1:0]     mr_o
);

  logic [TW:0]   twr_ext;
  logic [TW:0]   twr_even;
  logic [TW:0]   twr_m4;
  logic [2:0]    wr_code;
  logic [TW-1:0] cl_m4;
  logic [TW-1:0] cwl_m5;

  always_comb begin
    twr_ext  = {1'b0, twr_i};
    // Values above 8 rounded up to even before encoding (R8)
    twr_even = (twr_ext > (TW+1)'(8)) ? ((twr_ext + (TW+1)'(1)) & ~(TW+1)'(1)) : twr_ext;
    twr_m4   = twr_even - (TW+1)'(4);
    wr_code  = (twr_even <= (TW+1)'(8)) ? twr_m4[2:0] : twr_even[3:1];
    cl_m4    = tcl_i - TW'(4);
    cwl_m5   = tcwl_i - TW'(5);

    mr_o[0]        = '0;
    mr_o[0][11:9]  = wr_code;
    mr_o[0][8]     = 1'b1;
    mr_o[0][6:4]   = cl_m4[2:0];
    mr_o[0][2]     = cl_m4[3];

    mr_o[1]        = '0;
    mr_o[1][6]     = 1'b1;

    mr_o[2]        = '0;
    mr_o[2][5:3]   = cwl_m5[2:0];

    mr_o[3]        = '0;
  end

endmodule

// File: rtl/ddr3i_cmd_pack.sv
module ddr3i_cmd_pack
  import ddr3i_pkg::*;
(
  input  step_t                 step_i,
  input  logic [3:0][MRD_W-1:0] mr_i,
  output logic [WORD_W-1:0]     word_o
);

  always_comb begin
    word_o            = '0;
    word_o[START_POS] = 1'b1;
    word_o[RK1_POS]   = 1'b1;
    word_o[RK0_POS]   = 1'b1;
    word_o[3:0]       = step_i.op;
    if (step_i.op == OP_MRS) begin
      word_o[MRN_LSB +: 2]     = step_i.mr_sel;
      word_o[MRD_LSB +: MRD_W] = mr_i[step_i.mr_sel];
    end
  end

endmodule

// File: rtl/ddr3i_cycle_cnt.sv
module ddr3i_cycle_cnt #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         en_i,
  output logic [W-1:0] count_o
);

  logic [W-1:0] count_d;

  always_comb begin
    count_d = count_o;
    if (clr_i)     count_d = '0;
    else if (en_i) count_d = count_o + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              count_o <= '0;
    else if (clr_i || en_i)  count_o <= count_d;
  end

endmodule

// File: rtl/ddr3_bringup_seq.sv
module ddr3_bringup_seq
  import ddr3i_pkg::*;
#(
  parameter int unsigned TW              = 5,
  parameter int unsigned PWR_TIMEOUT_CYC = 25000,
  parameter int unsigned GAP_CYC         = 50
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [TW-1:0] twr_i,
  input  logic [TW-1:0] tcl_i,
  input  logic [TW-1:0] tcwl_i,
  output logic          pwr_req_o,
  input  logic          pwr_done_i,
  output logic          cmd_wr_o,
  output logic [31:0]   cmd_word_o,
  input  logic          cmd_pending_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_o
);

  localparam int unsigned CNT_MAX  = (PWR_TIMEOUT_CYC > GAP_CYC) ? PWR_TIMEOUT_CYC : GAP_CYC;
  localparam int unsigned CNT_W    = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] TO_LAST  = CNT_W'(PWR_TIMEOUT_CYC - 1);
  localparam logic [CNT_W-1:0] GAP_LAST = CNT_W'(GAP_CYC - 1);
  localparam logic [2:0]       LAST_STEP = 3'(NSTEP - 1);

  state_e        state_q, state_d;
  logic [2:0]    step_q, step_d;
  logic          done_q, done_d;
  logic          err_q, err_d;
  logic [TW-1:0] twr_q, tcl_q, tcwl_q;
  logic          load_en;
  logic          cnt_clr, cnt_en;
  logic [CNT_W-1:0] cnt;

  logic [3:0][MRD_W-1:0] mr_words;
  step_t                 cur_step;

  // Next-state logic
  always_comb begin
    state_d = state_q;
    step_d  = step_q;
    done_d  = done_q;
    err_d   = err_q;
    load_en = 1'b0;
    cnt_en  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d = ST_PWRUP;
          step_d  = '0;
          done_d  = 1'b0;
          err_d   = 1'b0;
          load_en = 1'b1;
        end
      end
      ST_PWRUP: begin
        if (pwr_done_i) begin
          state_d = ST_ISSUE;
          step_d  = '0;
        end else if (cnt == TO_LAST) begin
          state_d = ST_IDLE;
          err_d   = 1'b1;
        end else begin
          cnt_en  = 1'b1;
        end
      end
      ST_ISSUE: state_d = ST_ACKW;
      ST_ACKW: begin
        if (!cmd_pending_i) begin
          if (step_q == LAST_STEP) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
          end else if (step_q == 3'd0) begin
            state_d = ST_GAP;
          end else begin
            state_d = ST_ISSUE;
            step_d  = step_q + 3'd1;
          end
        end
      end
      ST_GAP: begin
        if (cnt == GAP_LAST) begin
          state_d = ST_ISSUE;
          step_d  = step_q + 3'd1;
        end else begin
          cnt_en  = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign cnt_clr = (state_d != state_q);

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  // Timing values captured only on an accepted start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      twr_q  <= '0;
      tcl_q  <= '0;
      tcwl_q <= '0;
    end else if (load_en) begin
      twr_q  <= twr_i;
      tcl_q  <= tcl_i;
      tcwl_q <= tcwl_i;
    end
  end

  ddr3i_cycle_cnt #(.W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (cnt_clr),
    .en_i    (cnt_en),
    .count_o (cnt)
  );

  ddr3i_mr_build #(.TW(TW)) u_mr (
    .twr_i  (twr_q),
    .tcl_i  (tcl_q),
    .tcwl_i (tcwl_q),
    .mr_o   (mr_words)
  );

  assign cur_step = step_of(step_q);

  ddr3i_cmd_pack u_pack (
    .step_i (cur_step),
    .mr_i   (mr_words),
    .word_o (cmd_word_o)
  );

  assign pwr_req_o = (state_q == ST_PWRUP);
  assign cmd_wr_o  = (state_q == ST_ISSUE);
  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = done_q;
  assign err_o     = err_q;

endmodule

// File: rtl/ddr3_bringup_seq_chk.sv
module ddr3_bringup_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start_i,
  input logic        pwr_req_o,
  input logic        cmd_wr_o,
  input logic [31:0] cmd_word_o,
  input logic        cmd_pending_i,
  input logic        busy_o,
  input logic        done_o,
  input logic        err_o
);

  assert_start_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> (busy_o && pwr_req_o && !done_o && !err_o));

  assert_word_flags_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr_o |-> (cmd_word_o[31] && cmd_word_o[21] && cmd_word_o[20]));

  assert_no_write_pending_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_pending_i |-> !cmd_wr_o);

  assert_no_cmd_in_power_R11: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_req_o |-> !cmd_wr_o);

  assert_end_flag_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> (done_o ^ err_o));

  assert_exclusive_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && err_o));

endmodule

bind ddr3_bringup_seq ddr3_bringup_seq_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .start_i       (start_i),
  .pwr_req_o     (pwr_req_o),
  .cmd_wr_o      (cmd_wr_o),
  .cmd_word_o    (cmd_word_o),
  .cmd_pending_i (cmd_pending_i),
  .busy_o        (busy_o),
  .done_o        (done_o),
  .err_o         (err_o)
);

// File: tb/ddr3_bringup_seq_bench.sv
module ddr3_bringup_seq_bench;

  localparam int TW      = 5;
  localparam int TIMEOUT = 200;
  localparam int GAP     = 40;

  logic          clk;
  logic          rst_n;
  logic          start_i;
  logic [TW-1:0] twr_i, tcl_i, tcwl_i;
  logic          pwr_req_o, pwr_done_i;
  logic          cmd_wr_o;
  logic [31:0]   cmd_word_o;
  logic          cmd_pending_i;
  logic          busy_o, done_o, err_o;

  int n_chk;
  int n_bad;

  // Controller model configuration (written only by tasks)
  int ack_lat;
  int pwr_lat;

  // Model state (written only by the model process)
  int          cyc;
  int          nw;
  int          viol;
  int          ackc;
  int          pwr_cnt;
  logic [31:0] wlog [0:63];
  int          wcyc [0:63];

  ddr3_bringup_seq #(
    .TW(TW), .PWR_TIMEOUT_CYC(TIMEOUT), .GAP_CYC(GAP)
  ) u_ddr3_bringup_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .twr_i         (twr_i),
    .tcl_i         (tcl_i),
    .tcwl_i        (tcwl_i),
    .pwr_req_o     (pwr_req_o),
    .pwr_done_i    (pwr_done_i),
    .cmd_wr_o      (cmd_wr_o),
    .cmd_word_o    (cmd_word_o),
    .cmd_pending_i (cmd_pending_i),
    .busy_o        (busy_o),
    .done_o        (done_o),
    .err_o         (err_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Controller model: start-flag readback and power-up completion
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc <= 0; nw <= 0; viol <= 0; ackc <= 0; pwr_cnt <= 0;
      cmd_pending_i <= 1'b0;
      pwr_done_i    <= 1'b0;
    end else begin
      cyc <= cyc + 1;
      if (pwr_req_o) begin
        pwr_cnt    <= pwr_cnt + 1;
        pwr_done_i <= (pwr_lat >= 0) && (pwr_cnt >= pwr_lat);
      end else begin
        pwr_cnt    <= 0;
        pwr_done_i <= 1'b0;
      end
      if (cmd_wr_o) begin
        if (cmd_pending_i) viol <= viol + 1;
        if (nw < 64) begin
          wlog[nw] <= cmd_word_o;
          wcyc[nw] <= cyc;
        end
        nw <= nw + 1;
        cmd_pending_i <= 1'b1;
        ackc <= ack_lat;
      end else if (cmd_pending_i) begin
        if (ackc == 0) cmd_pending_i <= 1'b0;
        else ackc <= ackc - 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic int exp_mr0(input int twr, input int cl);
    int w;
    int code;
    w = twr;
    if (w > 8) w = w + (w % 2);
    code = (w <= 8) ? (w - 4) : ((w / 2) % 8);
    return (code << 9) | (1 << 8) | (((cl - 4) % 8) << 4) | ((((cl - 4) / 8) % 2) << 2);
  endfunction

  function automatic int exp_mr(input int n, input int twr, input int cl, input int cwl);
    case (n)
      0: return exp_mr0(twr, cl);
      1: return 32'h040;
      2: return ((cwl - 5) % 8) << 3;
      default: return 0;
    endcase
  endfunction

  function automatic logic [31:0] exp_word(input int k, input int twr, input int cl, input int cwl);
    logic [31:0] w;
    int mrn;
    w = 32'h8030_0000;
    case (k)
      0: w[3:0] = 4'd0;
      1: w[3:0] = 4'd1;
      6: w[3:0] = 4'd5;
      default: begin
        mrn = (k == 2) ? 2 : (k == 3) ? 3 : (k == 4) ? 1 : 0;
        w[3:0]  = 4'd3;
        w[18:17] = 2'(mrn);
        w[16:4]  = 13'(exp_mr(mrn, twr, cl, cwl));
      end
    endcase
    return w;
  endfunction

  task automatic pulse_start(input int twr, input int cl, input int cwl);
    @(negedge clk);
    twr_i = TW'(twr); tcl_i = TW'(cl); tcwl_i = TW'(cwl);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_idle(input int limit);
    for (int i = 0; i < limit && busy_o; i++) @(negedge clk);
  endtask

  task automatic check_series(input string tag, input int base, input int twr, input int cl, input int cwl, input int v0);
    chk(nw - base == 7, "R4 word count", nw - base, 7);
    for (int k = 0; k < 7; k++) begin
      logic [31:0] e;
      e = exp_word(k, twr, cl, cwl);
      if (k == 5)      chk(wlog[base+k] == e, {tag, " R8 R9 MR0 word"}, wlog[base+k], e);
      else if (k >= 2) chk(wlog[base+k] == e, {tag, " R5 R10 MRS word"}, wlog[base+k], e);
      else             chk(wlog[base+k] == e, {tag, " R3 R4 command word"}, wlog[base+k], e);
    end
    chk(viol == v0, "R6 write while pending", viol - v0, 0);
    chk(wcyc[base+1] - wcyc[base] >= GAP + 1, "R7 settling gap", wcyc[base+1] - wcyc[base], GAP + 1);
    for (int k = 2; k < 7; k++)
      chk(wcyc[base+k] - wcyc[base+k-1] < GAP, "R7 no gap elsewhere", wcyc[base+k] - wcyc[base+k-1], GAP);
    chk(done_o && !err_o && !busy_o, "R12 done level", {done_o, err_o, busy_o}, 3'b100);
  endtask

  task automatic t_reset();
    chk({busy_o, done_o, err_o, pwr_req_o, cmd_wr_o} == 5'b0, "R1 in reset",
        {busy_o, done_o, err_o, pwr_req_o, cmd_wr_o}, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); @(negedge clk);
    chk({busy_o, done_o, err_o, pwr_req_o, cmd_wr_o} == 5'b0, "R1 after reset",
        {busy_o, done_o, err_o, pwr_req_o, cmd_wr_o}, 0);
  endtask

  task automatic t_seq(input string tag, input int twr, input int cl, input int cwl, input int al, input int pl);
    int base, v0;
    ack_lat = al; pwr_lat = pl;
    base = nw; v0 = viol;
    pulse_start(twr, cl, cwl);
    chk(busy_o && pwr_req_o && !done_o && !err_o, "R2 start accepted",
        {busy_o, pwr_req_o, done_o, err_o}, 4'b1100);
    wait_idle(3000);
    check_series(tag, base, twr, cl, cwl, v0);
    repeat (5) @(negedge clk);
    chk(done_o && !err_o, "R12 done held", {done_o, err_o}, 2'b10);
  endtask

  task automatic t_restart_ignored();
    int base, v0;
    ack_lat = 2; pwr_lat = 20;
    base = nw; v0 = viol;
    pulse_start(12, 11, 8);
    repeat (5) @(negedge clk);
    pulse_start(5, 6, 5);
    chk(busy_o && pwr_req_o, "R2 still in power phase", {busy_o, pwr_req_o}, 2'b11);
    wait_idle(3000);
    check_series("restart R2", base, 12, 11, 8, v0);
  endtask

  task automatic t_timeout();
    int base, t0, t1;
    ack_lat = 1; pwr_lat = -1;
    base = nw;
    pulse_start(10, 9, 7);
    t0 = cyc;
    repeat (TIMEOUT / 2) @(negedge clk);
    chk(busy_o && !err_o, "R11 still waiting", {busy_o, err_o}, 2'b10);
    wait_idle(3 * TIMEOUT);
    t1 = cyc;
    chk(err_o && !done_o && !busy_o, "R11 timeout error", {err_o, done_o, busy_o}, 3'b100);
    chk(t1 - t0 >= TIMEOUT, "R11 timeout length", t1 - t0, TIMEOUT);
    chk(nw == base, "R11 no command written", nw - base, 0);
    repeat (4) @(negedge clk);
    chk(err_o && !done_o, "R12 error held", {err_o, done_o}, 2'b10);
  endtask

  initial begin
    n_chk = 0; n_bad = 0;
    rst_n = 1'b0; start_i = 1'b0;
    twr_i = '0; tcl_i = '0; tcwl_i = '0;
    ack_lat = 0; pwr_lat = 0;
    repeat (3) @(negedge clk);
    t_reset();
    t_seq("wr8 boundary",  8,  6,  5, 0, 0);
    t_seq("wr5 low",       5,  5,  6, 3, 4);
    t_seq("wr9 round",     9, 11,  8, 1, 10);
    t_seq("wr12 cl13",    12, 13, 10, 5, 2);
    t_seq("wr16 wrap",    16, 14, 12, 2, 150);
    t_timeout();
    t_seq("after error",  10,  7,  7, 4, 1);
    t_restart_ignored();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #2000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule